// File: doc/BRIEF.md
# Control Endpoint Protocol Guard

This block watches the control pipe of a USB device (endpoint zero) and decides when the endpoint must refuse the host with a STALL handshake. A SETUP token starts a transfer. The request's direction and byte count go with it. The block then follows the transfer through its data stage, or straight to the status stage when the request carries no data. It counts the bytes that move in the data stage, and it notes when software has marked the end of the data.

The block recognises these protocol violations:
- an extra OUT packet after the data stage of an OUT request has ended;
- an extra IN request after software has finished the data stage of an IN request;
- an OUT packet larger than the endpoint's maximum packet size;
- a status-stage OUT packet that carries data.

A zero-length OUT that arrives before the full requested length has moved means the host has ended the transfer early. The block then flushes any IN packet waiting in the FIFO and raises a setup-end flag. The host-side token decoder and the FIFO sit around this block. They feed it one token per cycle and act on its three registered outputs.

Top module: `ep0_stall_guard`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `stall`, `flush_in` and `setup_end` are all low.
- R2: The token code on `tok_kind` is 2'b01 for SETUP, 2'b10 for IN and 2'b11 for OUT. A valid SETUP clears `stall` and `setup_end` at the next edge. It starts a new transfer from whatever state the block is in. When `req_len` is zero the transfer goes to the status stage. Otherwise `req_dir_in` high selects an IN data stage and low selects an OUT data stage.
- R3: In an OUT data stage, an OUT token that arrives once the data end is known raises `stall` at the next edge.
- R4: In an IN data stage, an IN token that arrives once the data end is known raises `stall` if `tx_ready` is low. If `tx_ready` is high, the IN token is accepted as a data packet and no stall is raised.
- R5: In any active stage, an OUT token whose `pkt_len` exceeds `max_pkt` raises `stall`. This rule takes priority over every other rule.
- R6: In an IN data stage, an OUT token with nonzero length is a malformed status packet and raises `stall`.
- R7: In either data stage, a zero-length OUT that arrives while the byte count is below `req_len` is a premature end. It drives `flush_in` high for exactly one cycle, sets `setup_end` and ends the transfer without a stall.
- R8: In an IN data stage, a zero-length OUT that arrives once the byte count has reached `req_len` completes the transfer without flush, setup-end or stall. Tokens other than SETUP are then ignored until the next SETUP.
- R9: Once raised, `stall` holds until the next SETUP. Tokens that arrive while it is set change no output.
- R10: A `data_end` strobe in the same cycle as a token counts as already known for that token.
- R11: In the status stage of a request with no data, an IN token completes the transfer. A later OUT of any size is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | A token is presented this cycle |
| tok_kind | input | 2 | Token code: 01 SETUP, 10 IN, 11 OUT |
| pkt_len | input | LEN_W | Bytes in the packet that belongs to the token |
| max_pkt | input | LEN_W | Maximum packet size of the endpoint |
| req_dir_in | input | 1 | Request direction, sampled with SETUP (1 = device to host) |
| req_len | input | CNT_W | Request byte count, sampled with SETUP |
| data_end | input | 1 | Software strobe: last data packet handled |
| tx_ready | input | 1 | An IN packet is loaded and waiting |
| stall | output | 1 | Answer the host with STALL (latched) |
| flush_in | output | 1 | One-cycle pulse: discard the queued IN packet |
| setup_end | output | 1 | The transfer was ended early by the host |

## Verification
The `data_end` strobe and a token can land in the same cycle. The block must then judge the token as if the data end were already known. The bench provokes this with an OUT token in an OUT data stage and an IN token in an IN data stage, each carrying the strobe in its own cycle. The expected stall one edge later shows that the strobe counted for that token. A SETUP that coincides with the end of a stage is also exercised; it must win over any pending verdict. On every clock, the bench compares all three outputs with a behavioural model. It also checks the outputs at fixed points against values derived directly from the rules.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_SETUP = 2'b01,
    TK_IN    = 2'b10,
    TK_OUT   = 2'b11
  } ep0_tok_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DIN  = 2'd1,
    PH_DOUT = 2'd2,
    PH_STAT = 2'd3
  } ep0_phase_e;

  typedef struct packed {
    logic stall;
    logic premature;
    logic done;
    logic accum;
  } ep0_verdict_t;

endpackage

// File: rtl/ep0_rule_check.sv
module ep0_rule_check
  import ep0_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 16
) (
  input  ep0_phase_e        phase,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LEN_W-1:0]  max_pkt,
  input  logic              de_eff,
  input  logic              tx_ready,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  req_len_q,
  output ep0_verdict_t      verdict
);

  logic is_in, is_out, oversize, short_xfer, zero_len;

  always_comb begin
    is_in      = tok_valid && (ep0_tok_e'(tok_kind) == TK_IN);
    is_out     = tok_valid && (ep0_tok_e'(tok_kind) == TK_OUT);
    oversize   = pkt_len > max_pkt;
    short_xfer = count < req_len_q;
    zero_len   = (pkt_len == '0);
  end

  always_comb begin
    verdict = '0;
    unique case (phase)
      PH_DOUT: begin
        if (is_out) begin
          if (oversize || de_eff)          verdict.stall     = 1'b1;
          else if (zero_len && short_xfer) verdict.premature = 1'b1;
          else                             verdict.accum     = 1'b1;
        end else if (is_in && de_eff) begin
          verdict.done = 1'b1;
        end
      end
      PH_DIN: begin
        if (is_out) begin
          if (oversize || !zero_len) verdict.stall     = 1'b1;
          else if (short_xfer)       verdict.premature = 1'b1;
          else                       verdict.done      = 1'b1;
        end else if (is_in) begin
          if (de_eff && !tx_ready) verdict.stall = 1'b1;
          else                     verdict.accum = 1'b1;
        end
      end
      PH_STAT: begin
        if (is_out && oversize) verdict.stall = 1'b1;
        else if (is_in)         verdict.done  = 1'b1;
      end
      default: verdict = '0;
    endcase
  end

endmodule

// File: rtl/ep0_phase_track.sv
module ep0_phase_track
  import ep0_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setup_hit,
  input  logic              req_dir_in,
  input  logic [CNT_W-1:0]  req_len,
  input  logic              data_end,
  input  logic [LEN_W-1:0]  pkt_len,
  input  ep0_verdict_t      verdict,
  output ep0_phase_e        phase,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  req_len_q,
  output logic              de_eff
);

  localparam int SUM_W = CNT_W + 1;
  localparam int PAD_W = SUM_W - LEN_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             de_seen;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] count_sat;
  logic             finish;

  assign de_eff = de_seen | data_end;
  assign finish = verdict.stall | verdict.premature | verdict.done;

  always_comb begin
    sum       = {1'b0, count} + {{PAD_W{1'b0}}, pkt_len};
    count_sat = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      count     <= '0;
      req_len_q <= '0;
      de_seen   <= 1'b0;
    end else if (setup_hit) begin
      req_len_q <= req_len;
      count     <= '0;
      de_seen   <= 1'b0;
      if (req_len == '0)   phase <= PH_STAT;
      else if (req_dir_in) phase <= PH_DIN;
      else                 phase <= PH_DOUT;
    end else if (phase != PH_IDLE) begin
      if (finish) begin
        phase   <= PH_IDLE;
        de_seen <= 1'b0;
      end else begin
        de_seen <= de_eff;
        if (verdict.accum) count <= count_sat;
      end
    end
  end

endmodule

// File: rtl/ep0_stall_guard.sv
module ep0_stall_guard
  import ep0_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LEN_W-1:0]  max_pkt,
  input  logic              req_dir_in,
  input  logic [CNT_W-1:0]  req_len,
  input  logic              data_end,
  input  logic              tx_ready,
  output logic              stall,
  output logic              flush_in,
  output logic              setup_end
);

  ep0_phase_e       phase;
  ep0_verdict_t     verdict;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] req_len_q;
  logic             de_eff;
  logic             setup_hit;

  assign setup_hit = tok_valid && (ep0_tok_e'(tok_kind) == TK_SETUP);

  ep0_phase_track #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .setup_hit(setup_hit), .req_dir_in(req_dir_in),
    .req_len(req_len), .data_end(data_end), .pkt_len(pkt_len),
    .verdict(verdict), .phase(phase), .count(count),
    .req_len_q(req_len_q), .de_eff(de_eff)
  );

  ep0_rule_check #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_rules (
    .phase(phase), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .pkt_len(pkt_len), .max_pkt(max_pkt), .de_eff(de_eff),
    .tx_ready(tx_ready), .count(count), .req_len_q(req_len_q),
    .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stall     <= 1'b0;
      flush_in  <= 1'b0;
      setup_end <= 1'b0;
    end else if (setup_hit) begin
      stall     <= 1'b0;
      flush_in  <= 1'b0;
      setup_end <= 1'b0;
    end else begin
      stall     <= stall | verdict.stall;
      flush_in  <= verdict.premature;
      setup_end <= setup_end | verdict.premature;
    end
  end

endmodule

// File: rtl/ep0_stall_guard_chk.sv
module ep0_stall_guard_chk
  import ep0_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             tok_valid,
  input logic [1:0]       tok_kind,
  input logic [LEN_W-1:0] pkt_len,
  input logic [LEN_W-1:0] max_pkt,
  input logic             stall,
  input logic             flush_in,
  input logic             setup_end,
  input ep0_phase_e       phase
);

  logic is_setup;
  assign is_setup = tok_valid && (tok_kind == 2'b01);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!stall && !flush_in && !setup_end));

  p_setup_clears_r2: assert property (@(posedge clk) disable iff (rst)
    is_setup |=> (!stall && !setup_end));

  p_oversize_stalls_r5: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'b11 && pkt_len > max_pkt && phase != PH_IDLE && !is_setup)
      |=> stall);

  p_flush_single_r7: assert property (@(posedge clk) disable iff (rst)
    flush_in |=> !flush_in);

  p_flush_marks_end_r7: assert property (@(posedge clk) disable iff (rst)
    flush_in |-> (setup_end && !stall));

  p_stall_latched_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && !is_setup) |=> stall);

  p_stall_idles_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && !is_setup) |-> (phase == PH_IDLE));

endmodule

bind ep0_stall_guard ep0_stall_guard_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
  .pkt_len(pkt_len), .max_pkt(max_pkt), .stall(stall),
  .flush_in(flush_in), .setup_end(setup_end), .phase(phase)
);

// File: tb/tb_ep0_stall_guard.sv
`timescale 1ns/1ps
module tb_ep0_stall_guard;

  localparam int LEN_W = 11;
  localparam int CNT_W = 16;
  localparam logic [1:0] K_NONE = 2'b00, K_SETUP = 2'b01, K_IN = 2'b10, K_OUT = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_valid = 1'b0;
  logic [1:0] tok_kind = K_NONE;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [LEN_W-1:0] max_pkt = 11'd64;
  logic req_dir_in = 1'b0;
  logic [CNT_W-1:0] req_len = '0;
  logic data_end = 1'b0;
  logic tx_ready = 1'b0;
  logic stall, flush_in, setup_end;

  always #4 clk = ~clk;

  ep0_stall_guard #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .pkt_len(pkt_len), .max_pkt(max_pkt), .req_dir_in(req_dir_in),
    .req_len(req_len), .data_end(data_end), .tx_ready(tx_ready),
    .stall(stall), .flush_in(flush_in), .setup_end(setup_end)
  );

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";
  bit finished = 0;

  // behavioural model: 0 idle, 1 IN data, 2 OUT data, 3 status
  int m_ph = 0, m_cnt = 0, m_rlen = 0;
  bit m_de = 0, m_stall = 0, m_flush = 0, m_se = 0;

  task automatic model_step();
    bit dee, fin, stl, pre, isin, isout, over;
    int len;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_rlen = 0; m_de = 0;
      m_stall = 0; m_flush = 0; m_se = 0;
      return;
    end
    m_flush = 0;
    if (tok_valid && tok_kind == K_SETUP) begin
      m_stall = 0; m_se = 0; m_cnt = 0; m_de = 0; m_rlen = int'(req_len);
      m_ph = (req_len == 0) ? 3 : (req_dir_in ? 1 : 2);
      return;
    end
    if (m_ph == 0) return;
    len = int'(pkt_len);
    dee = m_de || data_end;
    isin = tok_valid && tok_kind == K_IN;
    isout = tok_valid && tok_kind == K_OUT;
    over = len > int'(max_pkt);
    fin = 0; stl = 0; pre = 0;
    if (isout && over) stl = 1;
    else if (m_ph == 2) begin
      if (isout) begin
        if (dee) stl = 1;
        else if (len == 0 && m_cnt < m_rlen) pre = 1;
        else m_cnt = (m_cnt + len > 65535) ? 65535 : m_cnt + len;
      end else if (isin && dee) fin = 1;
    end else if (m_ph == 1) begin
      if (isout) begin
        if (len != 0) stl = 1;
        else if (m_cnt < m_rlen) pre = 1;
        else fin = 1;
      end else if (isin) begin
        if (dee && !tx_ready) stl = 1;
        else m_cnt = (m_cnt + len > 65535) ? 65535 : m_cnt + len;
      end
    end else if (m_ph == 3) begin
      if (isin) fin = 1;
    end
    if (stl) m_stall = 1;
    if (pre) begin m_flush = 1; m_se = 1; end
    if (stl || pre || fin) begin m_ph = 0; m_de = 0; end
    else m_de = dee;
  endtask

  task automatic compare_model();
    n_checks++;
    if (stall !== m_stall || flush_in !== m_flush || setup_end !== m_se) begin
      n_fail++;
      $display("FAIL %s model: actual stall=%b flush=%b setup_end=%b expected %b %b %b",
               tag, stall, flush_in, setup_end, m_stall, m_flush, m_se);
    end
  endtask

  task automatic expect3(input string req, input bit es, input bit ef, input bit ee);
    n_checks++;
    if (stall !== es || flush_in !== ef || setup_end !== ee) begin
      n_fail++;
      $display("FAIL %s: actual stall=%b flush=%b setup_end=%b expected %b %b %b",
               req, stall, flush_in, setup_end, es, ef, ee);
    end
  endtask

  task automatic cyc(input logic [1:0] k, input int len, input bit de, input bit txr);
    tok_valid = (k != K_NONE);
    tok_kind  = k;
    pkt_len   = LEN_W'(len);
    data_end  = de;
    tx_ready  = txr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_model();
    tok_valid = 1'b0; tok_kind = K_NONE; pkt_len = '0; data_end = 1'b0;
  endtask

  task automatic setup(input bit dir_in, input int rlen);
    req_dir_in = dir_in;
    req_len = CNT_W'(rlen);
    cyc(K_SETUP, 8, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1"; expect3("R1", 0, 0, 0);
    rst = 1'b0;
    cyc(K_NONE, 0, 0, 0);
    expect3("R1", 0, 0, 0);

    // R3: OUT request, extra OUT after data end
    tag = "R3";
    setup(0, 100);
    cyc(K_OUT, 64, 0, 0);
    cyc(K_OUT, 36, 0, 0);
    cyc(K_NONE, 0, 1, 0);
    expect3("R3", 0, 0, 0);
    cyc(K_OUT, 4, 0, 0);
    expect3("R3", 1, 0, 0);
    // R9: stall holds, tokens ignored
    tag = "R9";
    cyc(K_IN, 0, 0, 0);
    cyc(K_OUT, 0, 0, 0);
    expect3("R9", 1, 0, 0);
    // R2: SETUP clears stall
    tag = "R2";
    setup(0, 20);
    expect3("R2", 0, 0, 0);
    cyc(K_OUT, 20, 0, 0);
    cyc(K_NONE, 0, 1, 0);
    cyc(K_IN, 0, 0, 0);
    expect3("R2", 0, 0, 0);

    // R4: IN request, extra IN with tx_ready low / high
    tag = "R4";
    setup(1, 10);
    cyc(K_IN, 10, 0, 1);
    cyc(K_NONE, 0, 1, 0);
    cyc(K_IN, 0, 0, 1);
    expect3("R4", 0, 0, 0);
    cyc(K_IN, 0, 0, 0);
    expect3("R4", 1, 0, 0);

    // R5: oversized OUT
    tag = "R5";
    setup(0, 200);
    cyc(K_OUT, 65, 0, 0);
    expect3("R5", 1, 0, 0);

    // R7: premature zero-length OUT in IN stage
    tag = "R7";
    setup(1, 40);
    cyc(K_IN, 8, 0, 1);
    cyc(K_OUT, 0, 0, 0);
    expect3("R7", 0, 1, 1);
    cyc(K_NONE, 0, 0, 0);
    expect3("R7", 0, 0, 1);
    tag = "R2";
    setup(0, 30);
    expect3("R2", 0, 0, 0);
    // R7: premature in OUT stage
    tag = "R7";
    cyc(K_OUT, 16, 0, 0);
    cyc(K_OUT, 0, 0, 0);
    expect3("R7", 0, 1, 1);

    // R6: malformed status OUT
    tag = "R6";
    setup(1, 16);
    cyc(K_IN, 16, 0, 1);
    cyc(K_OUT, 3, 0, 0);
    expect3("R6", 1, 0, 0);

    // R8: normal IN completion, then ignored tokens
    tag = "R8";
    setup(1, 16);
    cyc(K_IN, 16, 0, 1);
    cyc(K_NONE, 0, 1, 0);
    cyc(K_OUT, 0, 0, 0);
    expect3("R8", 0, 0, 0);
    cyc(K_OUT, 9, 0, 0);
    cyc(K_IN, 0, 0, 0);
    expect3("R8", 0, 0, 0);

    // R10: data_end in same cycle as token
    tag = "R10";
    setup(0, 8);
    cyc(K_OUT, 8, 0, 0);
    cyc(K_OUT, 1, 1, 0);
    expect3("R10", 1, 0, 0);
    setup(1, 8);
    cyc(K_IN, 8, 0, 1);
    cyc(K_IN, 0, 1, 0);
    expect3("R10", 1, 0, 0);

    // R11: no-data request
    tag = "R11";
    setup(0, 0);
    cyc(K_IN, 0, 0, 0);
    cyc(K_OUT, 70, 0, 0);
    expect3("R11", 0, 0, 0);
    // R5 in status stage
    tag = "R5";
    setup(1, 0);
    cyc(K_OUT, 70, 0, 0);
    expect3("R5", 1, 0, 0);

    // R2: SETUP restarts mid-transfer, beats pending data_end
    tag = "R2";
    setup(0, 50);
    cyc(K_OUT, 10, 0, 0);
    req_dir_in = 1'b1; req_len = 16'd4;
    cyc(K_SETUP, 8, 1, 0);
    cyc(K_IN, 4, 0, 1);
    expect3("R2", 0, 0, 0);
    cyc(K_OUT, 0, 0, 0);
    expect3("R2", 0, 0, 0);

    finished = 1;
    summary();
  end

endmodule